// File: doc/BRIEF.md
# Multi-Channel DMA Register and Interrupt Interface

This block is the software-facing register slave of a multi-channel DMA controller. It keeps the per-channel programming words: source address, destination address, linked-list pointer, control and configuration. It also keeps a global configuration word and a sync word, the terminal-count and error pending bits, and a small table of read-only identification bytes. The transfer engine sits beside it. The engine reads the channel words, pulses a terminal-count or error set line when a channel finishes or faults, and pulses an enable-clear line when a channel retires.

Pending bits are filtered through each channel's own interrupt-enable bits in its configuration word. Both the raw and the filtered views can be read. Their union drives one level interrupt. The channel count is a parameter, 2 or 8, and it changes the first identification byte.

The bus is a plain register port with word address, write strobe, write data and combinational read data. The `reg_addr` port carries the byte offset divided by four. All offsets below are byte offsets.

Top module: `dmareg_ctrl`

## Requirements
- R1: After reset every channel word, the global configuration, the sync word and all pending bits read zero, and `irq` is low.
- R2: Channel c has its words at 0x100 + 0x20*c: source at +0x00, destination at +0x04, link at +0x08, control at +0x0C and configuration at +0x10. Each is a 32-bit read/write word. Offsets +0x14 to +0x1C read zero.
- R3: A channel window whose index (offset bits 7:5) is at or above NUM_CH reads zero, and writes to it change no register.
- R4: A pulse on bit c of `eng_tc_set` sets raw terminal-count bit c, readable at 0x014, from the next cycle on. The bit stays set until it is cleared. Bit c of `eng_err_set` does the same for raw error bit c at 0x018.
- R5: Masked terminal-count status at 0x004 is the raw bits ANDed with configuration bit 15 of each channel. Masked error status at 0x00C is the raw error bits ANDed with configuration bit 14.
- R6: Offset 0x000 reads the OR of masked terminal-count and masked error status.
- R7: Writing 0x008 clears each raw terminal-count bit where the written data has a 1. Writing 0x010 does the same for raw error bits. An engine set in the same cycle as a clear of the same bit wins, so the bit stays set.
- R8: `irq` is high exactly when the combined status at 0x000 is nonzero.
- R9: Offset 0x01C and port `chan_on` show configuration bit 0 of each channel. A pulse on `eng_en_clr` bit c clears that bit in the next cycle. A software write to the same configuration word in the same cycle takes priority.
- R10: The global configuration word at 0x030 and the sync word at 0x034 are 32-bit read/write. Offsets 0x020 to 0x02C read zero and ignore writes. The raw and masked status words are read-only.
- R11: Offsets 0xFE0 to 0xFFC read one identification byte per word, in the order 0x80/0x81, 0x10, 0x04, 0x0A, 0x0D, 0xF0, 0x05, 0xB1. The first byte is 0x80 when NUM_CH is 8 and 0x81 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 10 | Word address (byte offset / 4) |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| eng_tc_set | input | NUM_CH | Terminal-count set pulses from the engine |
| eng_err_set | input | NUM_CH | Error set pulses from the engine |
| eng_en_clr | input | NUM_CH | Channel enable-clear pulses from the engine |
| chan_on | output | NUM_CH | Enable bit of each channel |
| irq | output | 1 | Level interrupt |

## Verification
Two pairs of events can land in the same cycle: a software clear and an engine set on the pending bits, and a software configuration write and an engine enable-clear on the enable bits. The bench provokes both in one cycle. In the first case, bit 0 is set while a clear mask covers bits 0 and 1; bit 0 must survive and bit 1 must go. In the second case, an enable-clear coincides with a rewrite of that channel's configuration, and the enable bit must stay set. A clear or enable-clear on its own is also checked, to show that each takes effect when nothing competes with it.

// File: rtl/dmareg_pkg.sv
package dmareg_pkg;
  localparam int REG_W         = 32;
  localparam int WADDR_W       = 10;
  localparam int CFG_ON_BIT    = 0;
  localparam int CFG_ERRIE_BIT = 14;
  localparam int CFG_TCIE_BIT  = 15;

  typedef enum logic [2:0] {
    SLOT_SRC  = 3'd0,
    SLOT_DST  = 3'd1,
    SLOT_LINK = 3'd2,
    SLOT_CTRL = 3'd3,
    SLOT_CFG  = 3'd4
  } slot_e;

  typedef struct packed {
    logic [REG_W-1:0] src;
    logic [REG_W-1:0] dst;
    logic [REG_W-1:0] link;
    logic [REG_W-1:0] ctrl;
    logic [REG_W-1:0] cfg;
  } chan_words_t;

  function automatic logic [7:0] ident_byte(input logic [2:0] idx, input int nch);
    case (idx)
      3'd0:    ident_byte = (nch == 8) ? 8'h80 : 8'h81;
      3'd1:    ident_byte = 8'h10;
      3'd2:    ident_byte = 8'h04;
      3'd3:    ident_byte = 8'h0A;
      3'd4:    ident_byte = 8'h0D;
      3'd5:    ident_byte = 8'hF0;
      3'd6:    ident_byte = 8'h05;
      default: ident_byte = 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/dmareg_decode.sv
module dmareg_decode
  import dmareg_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic [WADDR_W-1:0] waddr,
  input  logic               wr,
  output logic               chan_hit,
  output logic [2:0]         chan_idx,
  output logic [2:0]         slot,
  output logic               glob_hit,
  output logic [5:0]         glob_word,
  output logic               id_hit,
  output logic [NUM_CH-1:0]  chan_wr_sel,
  output logic               tc_clr_we,
  output logic               err_clr_we,
  output logic               gcfg_we,
  output logic               sync_we
);
  localparam logic [3:0] CHAN_WIN = 4'h1;
  localparam logic [3:0] GLOB_WIN = 4'h0;
  localparam logic [6:0] ID_WIN   = 7'h7F;

  logic slot_ok;

  always_comb begin
    chan_idx  = waddr[5:3];
    slot      = waddr[2:0];
    glob_word = waddr[5:0];
    slot_ok   = (waddr[2:0] <= 3'd4);
    chan_hit  = (waddr[9:6] == CHAN_WIN) && (int'(waddr[5:3]) < NUM_CH) && slot_ok;
    glob_hit  = (waddr[9:6] == GLOB_WIN);
    id_hit    = (waddr[9:3] == ID_WIN);
    tc_clr_we  = wr && glob_hit && (glob_word == 6'd2);
    err_clr_we = wr && glob_hit && (glob_word == 6'd4);
    gcfg_we    = wr && glob_hit && (glob_word == 6'd12);
    sync_we    = wr && glob_hit && (glob_word == 6'd13);
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_sel
    assign chan_wr_sel[c] = wr && chan_hit && (int'(chan_idx) == c);
  end
endmodule

// File: rtl/dmareg_chan_bank.sv
module dmareg_chan_bank
  import dmareg_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] wr_sel,
  input  logic [2:0]        wr_slot,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [NUM_CH-1:0] en_clr,
  output chan_words_t       words [NUM_CH]
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    chan_words_t cur_q, cur_d;
    logic        cur_ce;

    always_comb begin
      cur_d  = cur_q;
      cur_ce = wr_sel[c] | en_clr[c];
      if (en_clr[c]) cur_d.cfg[CFG_ON_BIT] = 1'b0;
      if (wr_sel[c]) begin
        case (slot_e'(wr_slot))
          SLOT_SRC:  cur_d.src  = wr_data;
          SLOT_DST:  cur_d.dst  = wr_data;
          SLOT_LINK: cur_d.link = wr_data;
          SLOT_CTRL: cur_d.ctrl = wr_data;
          SLOT_CFG:  cur_d.cfg  = wr_data;
          default:   cur_d      = cur_q;
        endcase
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cur_q <= '0;
      else if (cur_ce) cur_q <= cur_d;
    end

    assign words[c] = cur_q;
  end
endmodule

// File: rtl/dmareg_irq_core.sv
module dmareg_irq_core #(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] tc_set,
  input  logic [NUM_CH-1:0] err_set,
  input  logic              tc_clr_we,
  input  logic              err_clr_we,
  input  logic [NUM_CH-1:0] clr_mask,
  input  logic [NUM_CH-1:0] tc_mask,
  input  logic [NUM_CH-1:0] err_mask,
  output logic [NUM_CH-1:0] tc_raw,
  output logic [NUM_CH-1:0] err_raw,
  output logic [NUM_CH-1:0] tc_masked,
  output logic [NUM_CH-1:0] err_masked,
  output logic              irq
);
  logic [NUM_CH-1:0] tc_q, tc_d, err_q, err_d;
  logic              tc_ce, err_ce;

  always_comb begin
    tc_ce  = tc_clr_we  | (|tc_set);
    err_ce = err_clr_we | (|err_set);
    tc_d   = (tc_q  & ~(tc_clr_we  ? clr_mask : '0)) | tc_set;
    err_d  = (err_q & ~(err_clr_we ? clr_mask : '0)) | err_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tc_q  <= '0;
      err_q <= '0;
    end else begin
      if (tc_ce)  tc_q  <= tc_d;
      if (err_ce) err_q <= err_d;
    end
  end

  assign tc_raw     = tc_q;
  assign err_raw    = err_q;
  assign tc_masked  = tc_q & tc_mask;
  assign err_masked = err_q & err_mask;
  assign irq        = |(tc_masked | err_masked);
endmodule

// File: rtl/dmareg_ctrl.sv
module dmareg_ctrl
  import dmareg_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [WADDR_W-1:0] reg_addr,
  input  logic               reg_wr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  input  logic [NUM_CH-1:0]  eng_tc_set,
  input  logic [NUM_CH-1:0]  eng_err_set,
  input  logic [NUM_CH-1:0]  eng_en_clr,
  output logic [NUM_CH-1:0]  chan_on,
  output logic               irq
);
  logic              chan_hit, glob_hit, id_hit;
  logic [2:0]        chan_idx, slot;
  logic [5:0]        glob_word;
  logic [NUM_CH-1:0] chan_wr_sel;
  logic              tc_clr_we, err_clr_we, gcfg_we, sync_we;
  chan_words_t       words [NUM_CH];
  logic [NUM_CH-1:0] tc_mask, err_mask;
  logic [NUM_CH-1:0] tc_raw, err_raw, tc_masked, err_masked;
  logic [REG_W-1:0]  gcfg_q, gcfg_d, sync_q, sync_d;
  chan_words_t       sel_words;

  dmareg_decode #(.NUM_CH(NUM_CH)) u_dec (
    .waddr(reg_addr), .wr(reg_wr),
    .chan_hit(chan_hit), .chan_idx(chan_idx), .slot(slot),
    .glob_hit(glob_hit), .glob_word(glob_word), .id_hit(id_hit),
    .chan_wr_sel(chan_wr_sel), .tc_clr_we(tc_clr_we), .err_clr_we(err_clr_we),
    .gcfg_we(gcfg_we), .sync_we(sync_we)
  );

  dmareg_chan_bank #(.NUM_CH(NUM_CH)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_sel(chan_wr_sel), .wr_slot(slot),
    .wr_data(reg_wdata), .en_clr(eng_en_clr), .words(words)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_mask
    assign tc_mask[c]  = words[c].cfg[CFG_TCIE_BIT];
    assign err_mask[c] = words[c].cfg[CFG_ERRIE_BIT];
    assign chan_on[c]  = words[c].cfg[CFG_ON_BIT];
  end

  dmareg_irq_core #(.NUM_CH(NUM_CH)) u_irq (
    .clk(clk), .rst_n(rst_n), .tc_set(eng_tc_set), .err_set(eng_err_set),
    .tc_clr_we(tc_clr_we), .err_clr_we(err_clr_we),
    .clr_mask(reg_wdata[NUM_CH-1:0]), .tc_mask(tc_mask), .err_mask(err_mask),
    .tc_raw(tc_raw), .err_raw(err_raw), .tc_masked(tc_masked),
    .err_masked(err_masked), .irq(irq)
  );

  always_comb begin
    gcfg_d = gcfg_we ? reg_wdata : gcfg_q;
    sync_d = sync_we ? reg_wdata : sync_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gcfg_q <= '0;
      sync_q <= '0;
    end else begin
      if (gcfg_we) gcfg_q <= gcfg_d;
      if (sync_we) sync_q <= sync_d;
    end
  end

  always_comb begin
    sel_words = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (int'(chan_idx) == c) sel_words = words[c];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (chan_hit) begin
      case (slot_e'(slot))
        SLOT_SRC:  reg_rdata = sel_words.src;
        SLOT_DST:  reg_rdata = sel_words.dst;
        SLOT_LINK: reg_rdata = sel_words.link;
        SLOT_CTRL: reg_rdata = sel_words.ctrl;
        SLOT_CFG:  reg_rdata = sel_words.cfg;
        default:   reg_rdata = '0;
      endcase
    end else if (id_hit) begin
      reg_rdata = REG_W'(ident_byte(slot, NUM_CH));
    end else if (glob_hit) begin
      case (glob_word)
        6'd0:    reg_rdata = REG_W'(tc_masked | err_masked);
        6'd1:    reg_rdata = REG_W'(tc_masked);
        6'd3:    reg_rdata = REG_W'(err_masked);
        6'd5:    reg_rdata = REG_W'(tc_raw);
        6'd6:    reg_rdata = REG_W'(err_raw);
        6'd7:    reg_rdata = REG_W'(chan_on);
        6'd12:   reg_rdata = gcfg_q;
        6'd13:   reg_rdata = sync_q;
        default: reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/dmareg_checks.sv
module dmareg_checks #(
  parameter int NUM_CH = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [9:0]        reg_addr,
  input logic              reg_wr,
  input logic [31:0]       reg_wdata,
  input logic [NUM_CH-1:0] eng_tc_set,
  input logic [NUM_CH-1:0] eng_err_set,
  input logic [NUM_CH-1:0] eng_en_clr,
  input logic              irq,
  input logic [NUM_CH-1:0] tc_raw,
  input logic [NUM_CH-1:0] err_raw,
  input logic [NUM_CH-1:0] tc_mask,
  input logic [NUM_CH-1:0] chan_on
);
  assert_tc_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_tc_set != '0) |=> ((tc_raw & $past(eng_tc_set)) == $past(eng_tc_set)));

  assert_err_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_err_set != '0) |=> ((err_raw & $past(eng_err_set)) == $past(eng_err_set)));

  assert_tc_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 10'h002 && eng_tc_set == '0)
      |=> ((tc_raw & $past(reg_wdata[NUM_CH-1:0])) == '0));

  assert_err_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 10'h004 && eng_err_set == '0)
      |=> ((err_raw & $past(reg_wdata[NUM_CH-1:0])) == '0));

  assert_irq_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (((eng_tc_set & tc_mask) != '0) && !reg_wr) |=> irq);

  assert_en_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((eng_en_clr != '0) && !reg_wr) |=> ((chan_on & $past(eng_en_clr)) == '0));
endmodule

bind dmareg_ctrl dmareg_checks #(.NUM_CH(NUM_CH)) u_checks (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .eng_tc_set(eng_tc_set), .eng_err_set(eng_err_set),
  .eng_en_clr(eng_en_clr), .irq(irq), .tc_raw(tc_raw), .err_raw(err_raw),
  .tc_mask(tc_mask), .chan_on(chan_on)
);

// File: tb/dmareg_ctrl_test.sv
module dmareg_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata, rdata8;
  logic [NCH-1:0] eng_tc_set = '0, eng_err_set = '0, eng_en_clr = '0, chan_on;
  logic [7:0]  chan_on8;
  logic        irq, irq8;
  int total = 0, bad = 0, cycles = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmareg_ctrl #(.NUM_CH(NCH)) uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_tc_set(eng_tc_set),
    .eng_err_set(eng_err_set), .eng_en_clr(eng_en_clr), .chan_on(chan_on), .irq(irq));

  dmareg_ctrl #(.NUM_CH(8)) uut8 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(1'b0),
    .reg_wdata(32'h0), .reg_rdata(rdata8), .eng_tc_set(8'h0),
    .eng_err_set(8'h0), .eng_en_clr(8'h0), .chan_on(chan_on8), .irq(irq8));

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] off, input logic [31:0] d);
    @(negedge clk);
    reg_addr = off[11:2]; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] off, output logic [31:0] d);
    reg_addr = off[11:2];
    #1 d = reg_rdata;
  endtask

  task automatic rd_check(input string req, input logic [11:0] off, input logic [31:0] exp);
    logic [31:0] v;
    rd(off, v);
    check(req, v, exp);
  endtask

  task automatic t_reset();
    rd_check("R1 status", 12'h000, 0);
    rd_check("R1 raw tc", 12'h014, 0);
    rd_check("R1 enabled", 12'h01C, 0);
    rd_check("R1 ch0 src", 12'h100, 0);
    rd_check("R1 gcfg", 12'h030, 0);
    check("R1 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_chan_words();
    for (int c = 0; c < NCH; c++)
      for (int s = 0; s < 5; s++)
        wr(12'(12'h100 + 32*c + 4*s), 32'hA000_0000 + 32'(c*16 + s));
    for (int c = 0; c < NCH; c++)
      for (int s = 0; s < 5; s++)
        rd_check("R2 word", 12'(12'h100 + 32*c + 4*s), 32'hA000_0000 + 32'(c*16 + s));
    rd_check("R2 gap", 12'h114, 0);
    rd_check("R2 gap", 12'h13C, 0);
  endtask

  task automatic t_bad_chan();
    wr(12'h140, 32'hDEAD_BEEF);
    wr(12'h1F0, 32'h1234_5678);
    rd_check("R3 ch2 read", 12'h140, 0);
    rd_check("R3 ch7 read", 12'h1F0, 0);
    rd_check("R3 ch0 intact", 12'h100, 32'hA000_0000);
    rd_check("R3 ch1 intact", 12'h130, 32'hA000_0014);
  endtask

  task automatic t_tc_err();
    wr(12'h110, 32'h0000_8000);
    wr(12'h130, 32'h0000_4000);
    @(negedge clk); eng_tc_set = 2'b11;
    @(negedge clk); eng_tc_set = 2'b00;
    rd_check("R4 raw tc", 12'h014, 3);
    rd_check("R5 masked tc", 12'h004, 1);
    rd_check("R6 combined", 12'h000, 1);
    check("R8 irq high", {31'b0, irq}, 1);
    @(negedge clk); eng_err_set = 2'b11;
    @(negedge clk); eng_err_set = 2'b00;
    rd_check("R4 raw err", 12'h018, 3);
    rd_check("R5 masked err", 12'h00C, 2);
    rd_check("R6 combined", 12'h000, 3);
  endtask

  task automatic t_clear();
    wr(12'h008, 32'h1);
    rd_check("R7 tc clear", 12'h014, 2);
    rd_check("R5 masked after", 12'h004, 0);
    wr(12'h010, 32'h3);
    rd_check("R7 err clear", 12'h018, 0);
    rd_check("R6 combined zero", 12'h000, 0);
    check("R8 irq low", {31'b0, irq}, 0);
    @(negedge clk);
    reg_addr = 10'h002; reg_wdata = 32'h3; reg_wr = 1'b1; eng_tc_set = 2'b01;
    @(negedge clk);
    reg_wr = 1'b0; eng_tc_set = 2'b00;
    rd_check("R7 set beats clear", 12'h014, 1);
    check("R8 irq after race", {31'b0, irq}, 1);
    wr(12'h008, 32'h1);
  endtask

  task automatic t_enable();
    wr(12'h110, 32'h1);
    wr(12'h130, 32'h1);
    rd_check("R9 enabled", 12'h01C, 3);
    check("R9 chan_on", {30'b0, chan_on}, 3);
    @(negedge clk); eng_en_clr = 2'b01;
    @(negedge clk); eng_en_clr = 2'b00;
    rd_check("R9 after clr", 12'h01C, 2);
    rd_check("R9 ch0 cfg", 12'h110, 0);
    @(negedge clk);
    reg_addr = 10'h04C; reg_wdata = 32'h1; reg_wr = 1'b1; eng_en_clr = 2'b10;
    @(negedge clk);
    reg_wr = 1'b0; eng_en_clr = 2'b00;
    rd_check("R9 write wins", 12'h01C, 2);
  endtask

  task automatic t_global();
    wr(12'h030, 32'h0000_0005);
    wr(12'h034, 32'hA5A5_5A5A);
    rd_check("R10 gcfg", 12'h030, 32'h0000_0005);
    rd_check("R10 sync", 12'h034, 32'hA5A5_5A5A);
    wr(12'h020, 32'hFFFF_FFFF);
    rd_check("R10 soft req zero", 12'h020, 0);
    rd_check("R10 soft req zero", 12'h02C, 0);
    wr(12'h014, 32'hFFFF_FFFF);
    rd_check("R10 raw read-only", 12'h014, 0);
  endtask

  task automatic t_ident();
    logic [7:0] tbl [8];
    tbl = '{8'h81, 8'h10, 8'h04, 8'h0A, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    for (int k = 0; k < 8; k++)
      rd_check("R11 ident", 12'(12'hFE0 + 4*k), {24'b0, tbl[k]});
    reg_addr = 10'h3F8;
    #1 check("R11 ident 8ch", rdata8, 32'h80);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_chan_words();
    t_bad_chan();
    t_tc_err();
    t_clear();
    t_enable();
    t_global();
    t_ident();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule